// File: doc/BRIEF.md
# Ramp-Paced Multi-Rail Power-Up Sequencer

This block is the control state machine that brings up the supply rails of a multi-output power-management device. A timing-capacitor oscillator outside the block charges and discharges in alternating up and down ramps. The block sees each ramp top as a one-cycle `peak_i` pulse and each ramp bottom as a one-cycle `valley_i` pulse. The block counts these events and ties every rail turn-on and every protection check to a fixed ramp position. The rails are: a boost rail with soft-start, a negative rail, and a positive gate rail. An active-low drive for a delayed-output switch is also timed this way. Analog parts (ramp generator, comparators, regulators) are outside the block and reach it only as digital flags.

The states are OFF, CHECK, BOOST, NEG, DELAY, GATE, RUN and FAULT. The transitions are:

- OFF→CHECK when enable and input-supply-good are both high.
- CHECK→BOOST on the valley that closes the second down ramp.
- BOOST→NEG on the fourth peak.
- NEG→DELAY on the fifth peak.
- DELAY→GATE on the valley after the fifth peak, which is the start of the sixth up ramp.
- GATE→RUN or GATE→FAULT on the sixth peak, where the final check is made.
- Any active state→FAULT on a detected fault.
- Any state→OFF when enable or input-supply-good goes low.

Once in FAULT, the block stays latched off until enable is toggled or the input supply drops. A supply drop returns the block to OFF without setting the fault flag. In RUN the oscillator is stopped and the fault flags stay monitored.

Top module: `pwrseq_ramp_sequencer`

## Requirements
- R1: After reset, and in the cycle after `en_i` is seen low, all rail enables, `boost_ss_o`, `ramp_run_o` and `fault_o` are 0 and `dly_n_o` is 1. The outputs stay that way while `en_i` is low.
- R2: In OFF with `en_i` and `vin_ok_i` both high, the block enters CHECK one cycle later and raises `ramp_run_o`. `ramp_run_o` stays high through CHECK, BOOST, NEG, DELAY and GATE, and is low in every other state.
- R3: In CHECK, `cap_fault_i` or `ref_fault_i` latches a fault. `otp_i` latches a fault in CHECK only once the first peak has been counted.
- R4: The `valley_i` seen in CHECK after two peaks sets `boost_en_o` and gives exactly one cycle of `boost_ss_o`. `boost_en_o` is 0 before that point.
- R5: The fourth `peak_i` sets `neg_en_o`.
- R6: The fifth `peak_i` drives `dly_n_o` low. `dly_n_o` is low only while `neg_en_o` is high.
- R7: The `valley_i` after the fifth peak sets `pos_en_o`. `pos_en_o` is high only while `boost_en_o` and `neg_en_o` are high.
- R8: On the sixth `peak_i`, if all three `rail_pgood_i` bits and `ss_done_i` are 1, the block enters RUN: `ramp_run_o` goes to 0 and all rails stay on with `dly_n_o` low. Otherwise the block latches a fault.
- R9: In FAULT, `fault_o` is 1, all rail enables and `ramp_run_o` are 0 and `dly_n_o` is 1. This holds for as long as `en_i` and `vin_ok_i` stay high.
- R10: From BOOST onward, including RUN, `ref_fault_i`, `otp_i` or the `rail_fault_i` bit of an enabled rail latches a fault. The bit order is 0 boost, 1 negative, 2 positive gate. A fault bit of a rail not yet enabled has no effect.
- R11: `vin_ok_i` low in any state returns the block to OFF in the next cycle with `fault_o` 0. This clears a latched fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable; low powers the block down |
| vin_ok_i | input | 1 | Input supply above start threshold |
| peak_i | input | 1 | One-cycle pulse at a ramp top |
| valley_i | input | 1 | One-cycle pulse at a ramp bottom |
| ss_done_i | input | 1 | Boost soft-start finished |
| cap_fault_i | input | 1 | Timing-capacitor fault |
| ref_fault_i | input | 1 | Reference fault |
| otp_i | input | 1 | Over-temperature flag |
| rail_fault_i | input | 3 | Per-rail fault (0 boost, 1 negative, 2 gate) |
| rail_pgood_i | input | 3 | Per-rail power good, same order |
| boost_en_o | output | 1 | Boost rail enable |
| boost_ss_o | output | 1 | One-cycle soft-start trigger |
| neg_en_o | output | 1 | Negative rail enable |
| pos_en_o | output | 1 | Positive gate rail enable |
| dly_n_o | output | 1 | Delayed-output drive, active low |
| ramp_run_o | output | 1 | Runs the ramp oscillator |
| fault_o | output | 1 | Latched fault |

## Verification
The hardest situation to reach is a fault that lands at one exact ramp position. Examples are an over-temperature flag before versus after the first peak, or a rail fault that arrives just before and just after that rail is enabled. Both need the oscillator pulses and the fault flags lined up to the cycle. Directed cases place these faults against a counted peak position. A ramp-like pulse generator then runs under random stimulus: it follows `ramp_run_o` and alternates peaks and valleys with random spacing. Random fault, enable and supply drops are sprinkled on top, so faults fall into every stage. A bench model predicts every output on every cycle.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    localparam int NRAIL     = 3;
    localparam int RAIL_BST  = 0;
    localparam int RAIL_NEG  = 1;
    localparam int RAIL_GATE = 2;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_CHECK = 3'd1,
        ST_BOOST = 3'd2,
        ST_NEG   = 3'd3,
        ST_DELAY = 3'd4,
        ST_GATE  = 3'd5,
        ST_RUN   = 3'd6,
        ST_FAULT = 3'd7
    } seq_state_t;

endpackage

// File: rtl/pwrseq_peak_counter.sv
module pwrseq_peak_counter #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             count_en,
    input  logic             peak,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (count_en && peak && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/pwrseq_fault_mon.sv
module pwrseq_fault_mon #(
    parameter int NR = 3
) (
    input  logic          early_chk,
    input  logic          otp_chk,
    input  logic          live_chk,
    input  logic          cap_fault,
    input  logic          ref_fault,
    input  logic          otp,
    input  logic [NR-1:0] rail_en,
    input  logic [NR-1:0] rail_fault,
    output logic          fault_now
);

    logic [NR-1:0] rail_hit;

    for (genvar g = 0; g < NR; g++) begin : g_rail
        assign rail_hit[g] = rail_en[g] & rail_fault[g];
    end

    assign fault_now = (early_chk & cap_fault)
                     | ((early_chk | live_chk) & ref_fault)
                     | (otp_chk & otp)
                     | (|rail_hit);

endmodule

// File: rtl/pwrseq_ramp_sequencer.sv
module pwrseq_ramp_sequencer
    import pwrseq_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             vin_ok_i,
    input  logic             peak_i,
    input  logic             valley_i,
    input  logic             ss_done_i,
    input  logic             cap_fault_i,
    input  logic             ref_fault_i,
    input  logic             otp_i,
    input  logic [NRAIL-1:0] rail_fault_i,
    input  logic [NRAIL-1:0] rail_pgood_i,
    output logic             boost_en_o,
    output logic             boost_ss_o,
    output logic             neg_en_o,
    output logic             pos_en_o,
    output logic             dly_n_o,
    output logic             ramp_run_o,
    output logic             fault_o
);

    // peak-count positions at which each stage ends
    localparam logic [CNT_W-1:0] PK_SS    = CNT_W'(2);
    localparam logic [CNT_W-1:0] PK_NEG   = CNT_W'(3);
    localparam logic [CNT_W-1:0] PK_DLY   = CNT_W'(4);
    localparam logic [CNT_W-1:0] PK_GATE  = CNT_W'(5);
    localparam logic [CNT_W-1:0] PK_FINAL = CNT_W'(5);

    seq_state_t       state, nxt;
    logic [CNT_W-1:0] pk_cnt;
    logic             fault_now;
    logic             ramping;
    logic             otp_chk;
    logic             live_chk;
    logic [NRAIL-1:0] rail_on;

    assign ramping  = state inside {ST_CHECK, ST_BOOST, ST_NEG, ST_DELAY, ST_GATE};
    assign live_chk = state inside {ST_BOOST, ST_NEG, ST_DELAY, ST_GATE, ST_RUN};
    assign otp_chk  = live_chk || (state == ST_CHECK && pk_cnt != '0);

    always_comb begin
        rail_on            = '0;
        rail_on[RAIL_BST]  = boost_en_o;
        rail_on[RAIL_NEG]  = neg_en_o;
        rail_on[RAIL_GATE] = pos_en_o;
    end

    pwrseq_peak_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state == ST_OFF),
        .count_en (ramping),
        .peak     (peak_i),
        .count    (pk_cnt)
    );

    pwrseq_fault_mon #(.NR(NRAIL)) u_mon (
        .early_chk  (state == ST_CHECK),
        .otp_chk    (otp_chk),
        .live_chk   (live_chk),
        .cap_fault  (cap_fault_i),
        .ref_fault  (ref_fault_i),
        .otp        (otp_i),
        .rail_en    (rail_on),
        .rail_fault (rail_fault_i),
        .fault_now  (fault_now)
    );

    // next-state decode
    always_comb begin
        nxt = state;
        if (!en_i || !vin_ok_i) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:   nxt = ST_CHECK;
                ST_CHECK: if (fault_now) nxt = ST_FAULT;
                          else if (valley_i && pk_cnt == PK_SS) nxt = ST_BOOST;
                ST_BOOST: if (fault_now) nxt = ST_FAULT;
                          else if (peak_i && pk_cnt == PK_NEG) nxt = ST_NEG;
                ST_NEG:   if (fault_now) nxt = ST_FAULT;
                          else if (peak_i && pk_cnt == PK_DLY) nxt = ST_DELAY;
                ST_DELAY: if (fault_now) nxt = ST_FAULT;
                          else if (valley_i && pk_cnt == PK_GATE) nxt = ST_GATE;
                ST_GATE:  if (fault_now) nxt = ST_FAULT;
                          else if (peak_i && pk_cnt == PK_FINAL)
                              nxt = ((&rail_pgood_i) && ss_done_i) ? ST_RUN : ST_FAULT;
                ST_RUN:   if (fault_now) nxt = ST_FAULT;
                ST_FAULT: nxt = ST_FAULT;
                default:  nxt = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boost_en_o <= 1'b0;
            boost_ss_o <= 1'b0;
            neg_en_o   <= 1'b0;
            pos_en_o   <= 1'b0;
            dly_n_o    <= 1'b1;
            ramp_run_o <= 1'b0;
            fault_o    <= 1'b0;
        end else begin
            boost_en_o <= nxt inside {ST_BOOST, ST_NEG, ST_DELAY, ST_GATE, ST_RUN};
            boost_ss_o <= (nxt == ST_BOOST) && (state != ST_BOOST);
            neg_en_o   <= nxt inside {ST_NEG, ST_DELAY, ST_GATE, ST_RUN};
            pos_en_o   <= nxt inside {ST_GATE, ST_RUN};
            dly_n_o    <= !(nxt inside {ST_DELAY, ST_GATE, ST_RUN});
            ramp_run_o <= nxt inside {ST_CHECK, ST_BOOST, ST_NEG, ST_DELAY, ST_GATE};
            fault_o    <= nxt == ST_FAULT;
        end
    end

endmodule

// File: rtl/pwrseq_checker.sv
module pwrseq_checker (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic vin_ok_i,
    input logic boost_en_o,
    input logic boost_ss_o,
    input logic neg_en_o,
    input logic pos_en_o,
    input logic dly_n_o,
    input logic ramp_run_o,
    input logic fault_o
);

    AST_DISABLED_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!boost_en_o && !neg_en_o && !pos_en_o && dly_n_o && !ramp_run_o && !fault_o)); // R1

    AST_SS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        boost_ss_o |=> !boost_ss_o); // R4

    AST_SS_WITH_BOOST: assert property (@(posedge clk) disable iff (!rst_n)
        boost_ss_o |-> boost_en_o); // R4

    AST_DLY_NEEDS_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        !dly_n_o |-> neg_en_o); // R6

    AST_GATE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        pos_en_o |-> (neg_en_o && boost_en_o)); // R7

    AST_FAULT_OUTS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (!boost_en_o && !neg_en_o && !pos_en_o && dly_n_o && !ramp_run_o)); // R9

    AST_FAULT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && en_i && vin_ok_i) |=> fault_o); // R9

    AST_VIN_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !vin_ok_i |=> (!fault_o && !ramp_run_o && !boost_en_o)); // R11

endmodule

bind pwrseq_ramp_sequencer pwrseq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .vin_ok_i   (vin_ok_i),
    .boost_en_o (boost_en_o),
    .boost_ss_o (boost_ss_o),
    .neg_en_o   (neg_en_o),
    .pos_en_o   (pos_en_o),
    .dly_n_o    (dly_n_o),
    .ramp_run_o (ramp_run_o),
    .fault_o    (fault_o)
);

// File: tb/pwrseq_ramp_sequencer_test.sv
module pwrseq_ramp_sequencer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0, vin_ok_i = 1'b0, peak_i = 1'b0, valley_i = 1'b0;
    logic       ss_done_i = 1'b1, cap_fault_i = 1'b0, ref_fault_i = 1'b0, otp_i = 1'b0;
    logic [2:0] rail_fault_i = 3'b000, rail_pgood_i = 3'b111;
    logic       boost_en_o, boost_ss_o, neg_en_o, pos_en_o, dly_n_o, ramp_run_o, fault_o;

    int checks = 0;
    int fails  = 0;

    // bench reference: 0 off,1 check,2 boost,3 neg,4 delay,5 gate,6 run,7 fault
    int m_st  = 0;
    int m_cnt = 0;
    bit m_ss  = 1'b0;

    always #2 clk = ~clk;

    pwrseq_ramp_sequencer uut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .vin_ok_i(vin_ok_i),
        .peak_i(peak_i), .valley_i(valley_i), .ss_done_i(ss_done_i),
        .cap_fault_i(cap_fault_i), .ref_fault_i(ref_fault_i), .otp_i(otp_i),
        .rail_fault_i(rail_fault_i), .rail_pgood_i(rail_pgood_i),
        .boost_en_o(boost_en_o), .boost_ss_o(boost_ss_o), .neg_en_o(neg_en_o),
        .pos_en_o(pos_en_o), .dly_n_o(dly_n_o), .ramp_run_o(ramp_run_o),
        .fault_o(fault_o)
    );

    function automatic bit f_ramp(int s);  return s >= 1 && s <= 5; endfunction
    function automatic bit f_boost(int s); return s >= 2 && s <= 6; endfunction
    function automatic bit f_neg(int s);   return s >= 3 && s <= 6; endfunction
    function automatic bit f_gate(int s);  return s == 5 || s == 6; endfunction
    function automatic bit f_dlyn(int s);  return !(s >= 4 && s <= 6); endfunction

    function automatic bit f_fault_seen(int s, int c);
        bit f = 1'b0;
        if (s == 1) f = cap_fault_i || ref_fault_i || (otp_i && c >= 1);
        if (s >= 2 && s <= 6) f = ref_fault_i || otp_i;
        if (f_boost(s) && rail_fault_i[0]) f = 1'b1;
        if (f_neg(s)   && rail_fault_i[1]) f = 1'b1;
        if (f_gate(s)  && rail_fault_i[2]) f = 1'b1;
        return f;
    endfunction

    task automatic model_update();
        int ns;
        bit flt;
        flt = f_fault_seen(m_st, m_cnt);
        ns  = m_st;
        if (!en_i || !vin_ok_i) ns = 0;
        else if (m_st == 0) ns = 1;
        else if (m_st == 7) ns = 7;
        else if (flt) ns = 7;
        else if (m_st == 1 && valley_i && m_cnt == 2) ns = 2;
        else if (m_st == 2 && peak_i && m_cnt == 3) ns = 3;
        else if (m_st == 3 && peak_i && m_cnt == 4) ns = 4;
        else if (m_st == 4 && valley_i && m_cnt == 5) ns = 5;
        else if (m_st == 5 && peak_i && m_cnt == 5)
            ns = (rail_pgood_i == 3'b111 && ss_done_i) ? 6 : 7;
        if (m_st == 0) m_cnt = 0;
        else if (f_ramp(m_st) && peak_i && m_cnt < 7) m_cnt++;
        m_ss = (ns == 2) && (m_st != 2);
        m_st = ns;
    endtask

    task automatic chk(string tag, string ctx, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (%s): actual %b expected %b at %0t", tag, ctx, act, exp, $time);
        end
    endtask

    task automatic compare(string ctx);
        chk("R2", ctx, ramp_run_o, f_ramp(m_st));
        chk("R4", ctx, boost_en_o, f_boost(m_st));
        chk("R4", ctx, boost_ss_o, m_ss);
        chk("R5", ctx, neg_en_o,   f_neg(m_st));
        chk("R6", ctx, dly_n_o,    f_dlyn(m_st));
        chk("R7", ctx, pos_en_o,   f_gate(m_st));
        chk("R9", ctx, fault_o,    m_st == 7);
    endtask

    task automatic tick(string ctx);
        model_update();
        @(negedge clk);
        compare(ctx);
    endtask

    task automatic gap(int n, string ctx);
        for (int i = 0; i < n; i++) tick(ctx);
    endtask

    task automatic pk(string ctx);
        peak_i = 1'b1; tick(ctx); peak_i = 1'b0;
    endtask

    task automatic vl(string ctx);
        valley_i = 1'b1; tick(ctx); valley_i = 1'b0;
    endtask

    // power-off, then walk the ramps up to just before peak number stop_pk
    task automatic start_to(int stop_pk, string ctx);
        en_i = 1'b0; gap(2, ctx);
        en_i = 1'b1; vin_ok_i = 1'b1; gap(2, ctx);
        for (int k = 1; k < stop_pk; k++) begin
            gap(2, ctx); pk(ctx); gap(2, ctx); vl(ctx);
        end
        gap(2, ctx);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #400us;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        int osc_cnt;
        bit osc_up;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "reset", boost_en_o | neg_en_o | pos_en_o | ramp_run_o | fault_o, 1'b0);
        chk("R1", "reset dly", dly_n_o, 1'b1);

        // R1: enable low with supply good keeps everything off
        vin_ok_i = 1'b1; gap(5, "R1 en low");
        chk("R1", "en low waits", ramp_run_o, 1'b0);

        // full clean power-up, R2..R8
        start_to(6, "power-up");
        pk("R8 final peak");
        chk("R8", "run stops ramp", ramp_run_o, 1'b0);
        chk("R8", "run rails on", boost_en_o & neg_en_o & pos_en_o & !dly_n_o, 1'b1);
        gap(4, "run idle");

        // R10: rail fault in RUN latches
        rail_fault_i = 3'b100; tick("R10 run fault"); rail_fault_i = 3'b000;
        chk("R10", "run rail fault", fault_o, 1'b1);
        gap(3, "R9 hold");
        chk("R9", "fault held", fault_o, 1'b1);
        // R11: supply drop clears
        vin_ok_i = 1'b0; tick("R11 vin drop");
        chk("R11", "vin clears fault", fault_o, 1'b0);
        vin_ok_i = 1'b1;

        // R3: over-temperature ignored before first peak, latched after
        en_i = 1'b0; gap(2, "R3 prep"); en_i = 1'b1; gap(2, "R3 prep");
        otp_i = 1'b1; tick("R3 early otp"); otp_i = 1'b0;
        chk("R3", "otp before peak ignored", fault_o, 1'b0);
        pk("R3 p1"); otp_i = 1'b1; tick("R3 late otp"); otp_i = 1'b0;
        chk("R3", "otp after peak", fault_o, 1'b1);

        // R3: timing-capacitor fault in CHECK
        start_to(2, "R3 cap");
        cap_fault_i = 1'b1; tick("R3 cap fault"); cap_fault_i = 1'b0;
        chk("R3", "cap fault", fault_o, 1'b1);

        // R10: gate-rail fault before that rail is enabled has no effect
        start_to(4, "R10 early");
        rail_fault_i = 3'b110; tick("R10 early rail"); rail_fault_i = 3'b000;
        chk("R10", "unenabled rail ignored", fault_o, 1'b0);
        cap_fault_i = 1'b1; tick("R10 cap after check"); cap_fault_i = 1'b0;
        chk("R10", "cap ignored after check", fault_o, 1'b0);

        // R8: missing power-good at the final peak
        start_to(6, "R8 pgood");
        rail_pgood_i = 3'b101; pk("R8 bad pgood"); rail_pgood_i = 3'b111;
        chk("R8", "missing pgood faults", fault_o, 1'b1);
        start_to(6, "R8 ss");
        ss_done_i = 1'b0; pk("R8 no ss"); ss_done_i = 1'b1;
        chk("R8", "soft-start not done faults", fault_o, 1'b1);

        // random phase with a ramp-like pulse source
        en_i = 1'b0; tick("rand prep");
        osc_up = 1'b1; osc_cnt = 3;
        for (int n = 0; n < 30000; n++) begin
            en_i         = ($urandom_range(0, 499) != 0) ? (en_i | ($urandom_range(0, 3) == 0)) : 1'b0;
            vin_ok_i     = ($urandom_range(0, 699) != 0);
            cap_fault_i  = ($urandom_range(0, 2999) == 0);
            ref_fault_i  = ($urandom_range(0, 3999) == 0);
            otp_i        = ($urandom_range(0, 2999) == 0);
            rail_fault_i = {($urandom_range(0, 1999) == 0), ($urandom_range(0, 1999) == 0),
                            ($urandom_range(0, 1999) == 0)};
            rail_pgood_i = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(0, 7)) : 3'b111;
            ss_done_i    = ($urandom_range(0, 19) != 0);
            peak_i = 1'b0; valley_i = 1'b0;
            if (!ramp_run_o) begin
                osc_up = 1'b1; osc_cnt = $urandom_range(2, 6);
            end else if (osc_cnt == 0) begin
                if (osc_up) peak_i = 1'b1; else valley_i = 1'b1;
                osc_up = !osc_up; osc_cnt = $urandom_range(2, 8);
            end else begin
                osc_cnt--;
            end
            tick("random");
        end
        peak_i = 1'b0; valley_i = 1'b0;
        summary();
    end

endmodule